// File: doc/BRIEF.md
# Flash Bus Operation Decoder

This block is the device-side front end of a parallel NOR-style memory. It watches five active-low strobes (bus reset, chip select, output enable, write enable and address strobe) and classifies every system-clock cycle as one bus operation: reset, standby, output disable, read, write or illegal. It latches a 23-bit address and serves 16-bit words from a small register array that stands in for the memory storage.

Reads run in one of two modes, chosen by a mode input. In asynchronous mode the address follows the address pins while the address strobe is low, and the burst clock has no effect. In synchronous mode a burst start address is captured on the first qualifying event: a rising edge of the burst clock while the strobe is low, or a rising edge of the strobe. Each later burst-clock rising edge steps the address. A wait status tells the host when burst data is not yet valid. Stopping the burst clock suspends the burst. All pins are sampled on the system clock, and the burst clock is edge-detected against that clock. High-impedance is shown by separate drive-enable outputs.

Top module: `flash_bus_front`

## Requirements
- R1: Each cycle is decoded on `op` in this priority: bus reset low gives 0 (reset); chip select high gives 1 (standby); output enable and write enable both low gives 5 (illegal); write enable low gives 4 (write); output enable low with the address strobe low gives 3 (read); anything else gives 2 (output disable).
- R2: During reset the data and wait drive-enables are low, the illegal flag is low, and no word is written.
- R3: During standby the data and wait drive-enables are low and the illegal flag is low, whatever the other strobes are.
- R4: During output disable, which includes output enable low with the address strobe high, the data drive-enable is low.
- R5: During a write, `dq_in` is stored at the word whose index is `addr[3:0]`, and the data bus is not driven.
- R6: `illegal` is high in exactly the illegal cycles, and no word is written in such a cycle.
- R7: In asynchronous mode the read address register takes `addr` at each clock edge while the address strobe is low, so a read shows the word one cycle after the address is applied. The burst clock has no effect, and the wait output is not driven.
- R8: In synchronous mode the wait output is driven during reads and is high until a burst has started. The start address is taken from `addr` on the first burst-clock rising edge with the strobe low, or on a strobe rising edge, whichever comes first.
- R9: Once a burst has started, each burst-clock rising edge advances the address by one, and `addr` is ignored.
- R10: While the burst clock stays still, the address and the output word are held. The burst then resumes from the held address.
- R11: A started burst ends, with wait high again, after a falling edge of the address strobe, standby or bus reset.
- R12: After the synchronous reset `rst_n`, all words read zero and the address register is zero.
- R13: Only addresses with `addr[22:4]` equal to zero map to storage. Reads elsewhere return 16'hFFFF and writes elsewhere are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous active-low block reset |
| bus_rst_n | input | 1 | Bus reset strobe, active low |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| adv_n | input | 1 | Address strobe, active low |
| burst_clk | input | 1 | Burst clock, rising edges detected |
| sync_mode | input | 1 | 1 = synchronous burst reads, 0 = asynchronous |
| addr | input | 23 | Address pins |
| dq_in | input | 16 | Write data from the bus |
| dq_out | output | 16 | Read data toward the bus |
| dq_oe | output | 1 | Data bus drive-enable (0 = high-impedance) |
| wait_out | output | 1 | 1 = burst data not yet valid |
| wait_oe | output | 1 | Wait drive-enable (0 = high-impedance) |
| illegal | output | 1 | Output and write enable low together |
| op | output | 3 | Decoded bus operation code |

## Verification
Some properties are checked on every cycle: no data drive during reset or standby, no write during an illegal cycle, the asynchronous address register following the pins, single steps and exact holds of the burst counter, and wait being driven only in synchronous mode. Other behaviour can only be shown by the bench's scenarios, because it needs a known storage image and a sequence of strobe events. This covers which burst event captures the start address, a burst resuming after a suspend, a burst crossing the storage window into erased space, and a burst ended by a strobe falling edge.

// File: rtl/fbf_pkg.sv
// Shared definitions for the flash bus front end.
// Assumes: nothing beyond IEEE 1800-2017.
package fbf_pkg;
    typedef enum logic [2:0] {
        OP_RESET   = 3'd0,
        OP_STANDBY = 3'd1,
        OP_OUTDIS  = 3'd2,
        OP_READ    = 3'd3,
        OP_WRITE   = 3'd4,
        OP_ILLEGAL = 3'd5
    } bus_op_t;
endpackage

// File: rtl/fbf_decode.sv
// Strobe decoder: maps the five active-low strobes to one bus operation
// per cycle, together with read/write enables and the illegal flag.
// Assumes: strobes are already in the clk domain; clk/rst_n only clock
// the embedded checks.
module fbf_decode
    import fbf_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    bus_rst_n,
    input  logic    ce_n,
    input  logic    oe_n,
    input  logic    we_n,
    input  logic    adv_n,
    output bus_op_t op,
    output logic    rd_en,
    output logic    wr_en,
    output logic    illegal
);

    // Priority decode of the strobes into one operation.
    always_comb begin
        if (!bus_rst_n)          op = OP_RESET;
        else if (ce_n)           op = OP_STANDBY;
        else if (!oe_n && !we_n) op = OP_ILLEGAL;
        else if (!we_n)          op = OP_WRITE;
        else if (!oe_n && !adv_n) op = OP_READ;
        else                     op = OP_OUTDIS;
    end

    // Per-operation enables.
    always_comb begin
        rd_en   = (op == OP_READ);
        wr_en   = (op == OP_WRITE);
        illegal = (op == OP_ILLEGAL);
    end

    // R2/R3: no bus activity when deselected or in bus reset.
    p_quiet_deselect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rst_n || ce_n) |-> (!rd_en && !wr_en && !illegal));

    // R6: an illegal cycle never writes.
    p_illegal_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && !we_n) |-> !wr_en);

endmodule

// File: rtl/fbf_addr_ctrl.sv
// Address controller: holds the read address. In asynchronous mode it
// tracks the pins while the strobe is low. In synchronous mode it captures
// a burst start and then counts burst-clock rising edges.
// Assumes: burst_clk is slow against clk, so each of its edges is seen.
module fbf_addr_ctrl #(
    parameter int ADDR_W = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_mode,
    input  logic              bus_rst_n,
    input  logic              ce_n,
    input  logic              adv_n,
    input  logic              burst_clk,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              started
);

    logic adv_q;
    logic bclk_q;
    logic adv_rise;
    logic adv_fall;
    logic bedge;
    logic hard_clr;
    logic start;

    // Previous-cycle copies of the strobe and the burst clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adv_q  <= 1'b1;
            bclk_q <= 1'b0;
        end else begin
            adv_q  <= adv_n;
            bclk_q <= burst_clk;
        end
    end

    // Edge detection and burst start qualification.
    always_comb begin
        adv_rise = adv_n && !adv_q;
        adv_fall = !adv_n && adv_q;
        bedge    = burst_clk && !bclk_q;
        hard_clr = !bus_rst_n || ce_n;
        start    = sync_mode && (!started || adv_fall) &&
                   (adv_rise || (!adv_n && bedge));
    end

    // Address register and burst-active flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            started  <= 1'b0;
        end else if (!sync_mode) begin
            started <= 1'b0;
            if (!adv_n) cur_addr <= addr;
        end else if (hard_clr) begin
            started <= 1'b0;
        end else if (start) begin
            cur_addr <= addr;
            started  <= 1'b1;
        end else if (adv_fall) begin
            started <= 1'b0;
        end else if (started && bedge) begin
            cur_addr <= cur_addr + 1'b1;
        end
    end

    // R7: asynchronous mode tracks the pins while the strobe is low.
    p_async_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode && !adv_n) |=> (cur_addr == $past(addr)));

    // R9: a burst edge inside a running burst steps by exactly one.
    p_burst_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && started && bedge && adv_n && !adv_rise && !hard_clr)
        |=> (cur_addr == $past(cur_addr) + 1'b1));

    // R10: no burst edge and no strobe event means the address holds.
    p_suspend_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && !bedge && !adv_rise) |=> $stable(cur_addr));

endmodule

// File: rtl/fbf_store.sv
// Register array standing in for the memory storage. A window of
// DEPTH words sits at WIN_BASE; reads outside the window return erased
// data (all ones), and writes outside it are dropped.
// Assumes: DEPTH is a power of two.
module fbf_store #(
    parameter int ADDR_W = 23,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int WIN_BASE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int HI_W  = ADDR_W - IDX_W;
    localparam logic [HI_W-1:0] BASE = HI_W'(WIN_BASE);

    logic [DATA_W-1:0] mem [DEPTH];
    logic              w_hit;
    logic              r_hit;

    // Window hit for each port.
    always_comb begin
        w_hit = (waddr[ADDR_W-1:IDX_W] == BASE);
        r_hit = (raddr[ADDR_W-1:IDX_W] == BASE);
    end

    // Word storage, cleared by block reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en && w_hit) begin
            mem[waddr[IDX_W-1:0]] <= wdata;
        end
    end

    // Read mux with erased value outside the window.
    always_comb begin
        rdata = r_hit ? mem[raddr[IDX_W-1:0]] : '1;
    end

endmodule

// File: rtl/flash_bus_front.sv
// Top of the flash bus front end: decoder, address controller and
// storage, plus the drive-enable and wait logic at the pins.
// Assumes: all strobes synchronous to clk; high-impedance shown by the
// *_oe outputs.
module flash_bus_front #(
    parameter int ADDR_W   = 23,
    parameter int DATA_W   = 16,
    parameter int DEPTH    = 16,
    parameter int WIN_BASE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              adv_n,
    input  logic              burst_clk,
    input  logic              sync_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              wait_out,
    output logic              wait_oe,
    output logic              illegal,
    output logic [2:0]        op
);
    import fbf_pkg::*;

    bus_op_t           op_i;
    logic              rd_en;
    logic              wr_en;
    logic [ADDR_W-1:0] cur_addr;
    logic              started;
    logic [DATA_W-1:0] rdata;

    fbf_decode u_dec (
        .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n), .ce_n(ce_n),
        .oe_n(oe_n), .we_n(we_n), .adv_n(adv_n),
        .op(op_i), .rd_en(rd_en), .wr_en(wr_en), .illegal(illegal)
    );

    fbf_addr_ctrl #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode),
        .bus_rst_n(bus_rst_n), .ce_n(ce_n), .adv_n(adv_n),
        .burst_clk(burst_clk), .addr(addr),
        .cur_addr(cur_addr), .started(started)
    );

    fbf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
                .WIN_BASE(WIN_BASE)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .waddr(addr),
        .wdata(dq_in), .raddr(cur_addr), .rdata(rdata)
    );

    // Pin-side drive enables and wait status.
    always_comb begin
        op       = op_i;
        dq_out   = rdata;
        dq_oe    = rd_en;
        wait_oe  = rd_en && sync_mode;
        wait_out = wait_oe && !started;
    end

    // R8/R7: wait is only driven for synchronous reads.
    p_wait_sync_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wait_oe |-> (sync_mode && !oe_n && !ce_n));

    // R2: bus reset keeps both outputs off the bus.
    p_reset_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rst_n |-> (!dq_oe && !wait_oe && !illegal));

endmodule

// File: tb/flash_bus_front_test.sv
module flash_bus_front_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] E_RST = 3'd0, E_STBY = 3'd1, E_ODIS = 3'd2,
                           E_READ = 3'd3, E_WRITE = 3'd4, E_ILL = 3'd5;

    typedef struct {
        logic [2:0]  op;
        logic        oe;
        logic        cd;
        logic [15:0] dq;
        logic        woe;
        logic        w;
        logic        ill;
        string       req;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_rst_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic adv_n = 1'b1, burst_clk = 1'b0, sync_mode = 1'b0;
    logic [22:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic dq_oe, wait_out, wait_oe, illegal;
    logic [2:0] op;

    int total = 0;
    int bad = 0;
    item_t q[$];
    logic [15:0] model [16];

    flash_bus_front uut (
        .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n), .ce_n(ce_n),
        .oe_n(oe_n), .we_n(we_n), .adv_n(adv_n), .burst_clk(burst_clk),
        .sync_mode(sync_mode), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .wait_out(wait_out),
        .wait_oe(wait_oe), .illegal(illegal), .op(op)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] exp_rd(input logic [22:0] a);
        return (a[22:4] == 19'd0) ? model[a[3:0]] : 16'hFFFF;
    endfunction

    // Driver: apply one cycle of pins at the falling edge.
    task automatic go(input logic br, ce, oe, we, adv, bc, sm,
                      input logic [22:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_rst_n = br; ce_n = ce; oe_n = oe; we_n = we; adv_n = adv;
        burst_clk = bc; sync_mode = sm; addr = a; dq_in = d;
    endtask

    // Push the expected outputs for the cycle just driven.
    task automatic expect_(input logic [2:0] o, input logic oe, input logic cd,
                           input logic [15:0] dq, input logic woe,
                           input logic w, input logic ill, input string r);
        item_t e;
        e.op = o; e.oe = oe; e.cd = cd; e.dq = dq; e.woe = woe;
        e.w = w; e.ill = ill; e.req = r;
        q.push_back(e);
    endtask

    task automatic check_one(input bit ok, input string r, input string what,
                             input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    // Monitor: compare outputs shortly after each falling edge.
    always @(negedge clk) begin
        #2;
        if (q.size() > 0) begin
            item_t e;
            e = q.pop_front();
            check_one(op == e.op, e.req, "op", 16'(op), 16'(e.op));
            check_one(dq_oe == e.oe, e.req, "dq_oe", 16'(dq_oe), 16'(e.oe));
            check_one(illegal == e.ill, e.req, "illegal", 16'(illegal), 16'(e.ill));
            check_one(wait_oe == e.woe, e.req, "wait_oe", 16'(wait_oe), 16'(e.woe));
            if (e.cd) check_one(dq_out == e.dq, e.req, "dq_out", dq_out, e.dq);
            if (e.woe) check_one(wait_out == e.w, e.req, "wait_out", 16'(wait_out), 16'(e.w));
        end
    end

    // Asynchronous read: apply address, check the word one cycle later.
    task automatic aread(input logic [22:0] a, input string r);
        go(1, 0, 0, 1, 0, 0, 0, a, 16'h0);
        go(1, 0, 0, 1, 0, 0, 0, a, 16'h0);
        expect_(E_READ, 1, 1, exp_rd(a), 0, 0, 0, r);
    endtask

    // One burst clock pulse with junk address, then check the new word.
    task automatic bpulse(input logic [22:0] ea, input string r);
        go(1, 0, 0, 1, 0, 1, 1, 23'h2A5A5A, 16'h0);
        go(1, 0, 0, 1, 0, 0, 1, 23'h155555, 16'h0);
        expect_(E_READ, 1, 1, exp_rd(ea), 1, 0, 0, r);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state and standby.
        go(1, 1, 1, 1, 1, 0, 0, 23'h0, 16'h0);
        expect_(E_STBY, 0, 0, 16'h0, 0, 0, 0, "R12");
        go(1, 0, 0, 1, 0, 0, 0, 23'h0, 16'h0);
        expect_(E_READ, 1, 1, 16'h0, 0, 0, 0, "R12");
        go(1, 1, 0, 0, 0, 0, 0, 23'h0, 16'h0);
        expect_(E_STBY, 0, 0, 16'h0, 0, 0, 0, "R3");
        go(0, 0, 0, 0, 0, 0, 0, 23'h0, 16'hDEAD);
        expect_(E_RST, 0, 0, 16'h0, 0, 0, 0, "R2");

        // Fill storage.
        for (int i = 0; i < 16; i++) begin
            logic [15:0] d;
            d = 16'hA500 + 16'(i) * 16'h0111;
            go(1, 0, 1, 0, 0, 0, 0, 23'(i), d);
            expect_(E_WRITE, 0, 0, 16'h0, 0, 0, 0, "R5");
            model[i] = d;
        end
        go(1, 0, 1, 0, 0, 0, 0, 23'h000013, 16'h1234);
        expect_(E_WRITE, 0, 0, 16'h0, 0, 0, 0, "R1");

        // Asynchronous reads.
        aread(23'h3, "R7");
        aread(23'hA, "R5");
        aread(23'h0, "R5");
        aread(23'h400005, "R13");
        aread(23'h000013, "R13");
        aread(23'h7, "R7");
        go(1, 0, 0, 1, 0, 1, 0, 23'h7, 16'h0);
        expect_(E_READ, 1, 1, model[7], 0, 0, 0, "R7");
        go(1, 0, 0, 1, 0, 0, 0, 23'h7, 16'h0);
        expect_(E_READ, 1, 1, model[7], 0, 0, 0, "R7");
        go(1, 0, 0, 1, 1, 0, 0, 23'h7, 16'h0);
        expect_(E_ODIS, 0, 0, 16'h0, 0, 0, 0, "R4");
        go(1, 0, 1, 1, 0, 0, 0, 23'h7, 16'h0);
        expect_(E_ODIS, 0, 0, 16'h0, 0, 0, 0, "R4");

        // Illegal strobes: flag set, no write.
        go(1, 0, 0, 0, 0, 0, 0, 23'h4, 16'hFFFF);
        expect_(E_ILL, 0, 0, 16'h0, 0, 0, 1, "R6");
        aread(23'h4, "R6");

        // Synchronous burst from 2, start on burst clock edge.
        go(1, 1, 1, 1, 1, 0, 1, 23'h0, 16'h0);
        go(1, 0, 0, 1, 0, 0, 1, 23'h2, 16'h0);
        expect_(E_READ, 1, 0, 16'h0, 1, 1, 0, "R8");
        go(1, 0, 0, 1, 0, 1, 1, 23'h2, 16'h0);
        go(1, 0, 0, 1, 0, 0, 1, 23'h55, 16'h0);
        expect_(E_READ, 1, 1, model[2], 1, 0, 0, "R8");
        bpulse(23'h3, "R9");
        bpulse(23'h4, "R9");
        for (int k = 0; k < 3; k++) begin
            go(1, 0, 0, 1, 0, 0, 1, 23'h9, 16'h0);
            expect_(E_READ, 1, 1, model[4], 1, 0, 0, "R10");
        end
        bpulse(23'h5, "R10");

        // Burst across the window end.
        go(1, 1, 1, 1, 1, 0, 1, 23'h0, 16'h0);
        expect_(E_STBY, 0, 0, 16'h0, 0, 0, 0, "R11");
        go(1, 0, 0, 1, 0, 0, 1, 23'hE, 16'h0);
        go(1, 0, 0, 1, 0, 1, 1, 23'hE, 16'h0);
        go(1, 0, 0, 1, 0, 0, 1, 23'h0, 16'h0);
        expect_(E_READ, 1, 1, model[14], 1, 0, 0, "R9");
        bpulse(23'hF, "R9");
        bpulse(23'h10, "R13");

        // Strobe falling edge ends the burst.
        go(1, 0, 0, 1, 1, 0, 1, 23'h9, 16'h0);
        expect_(E_ODIS, 0, 0, 16'h0, 0, 0, 0, "R4");
        go(1, 0, 0, 1, 0, 0, 1, 23'h9, 16'h0);
        expect_(E_READ, 1, 1, 16'hFFFF, 1, 0, 0, "R11");
        go(1, 0, 0, 1, 0, 0, 1, 23'h9, 16'h0);
        expect_(E_READ, 1, 0, 16'h0, 1, 1, 0, "R11");

        // Start captured by a strobe rising edge.
        go(1, 0, 1, 1, 0, 0, 1, 23'h6, 16'h0);
        go(1, 0, 1, 1, 1, 0, 1, 23'h6, 16'h0);
        go(1, 0, 0, 1, 0, 0, 1, 23'h9, 16'h0);
        expect_(E_READ, 1, 1, model[6], 1, 0, 0, "R8");
        go(1, 0, 0, 1, 0, 0, 1, 23'h9, 16'h0);
        expect_(E_READ, 1, 0, 16'h0, 1, 1, 0, "R11");

        // Bus reset during sync mode.
        go(0, 0, 0, 1, 0, 0, 1, 23'h9, 16'h0);
        expect_(E_RST, 0, 0, 16'h0, 0, 0, 0, "R2");

        go(1, 1, 1, 1, 1, 0, 0, 23'h0, 16'h0);
        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog all-requirements actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule